// File: doc/BRIEF.md
# Banked Host Register File for an Optical-Drive Controller

This block is the byte-wide register window that a host processor uses to talk to an optical-drive controller. The host sees four offsets. A 2-bit bank index, written through offset 0, decides which register some offsets reach. The block contains three small synchronous byte queues: a parameter queue that the host fills, and a response queue and a data queue that the host drains. It also holds a 5-bit interrupt enable register, a 5-bit interrupt flag register and a level interrupt output.

Command bytes written by the host go out as a one-cycle strobe with the opcode to an external command sequencer. That sequencer reports whether it is busy, fills the response and data queues, reads parameters and raises interrupts by code. Offset 0 reads back a live status byte that is built from the queue states and the busy input.

Top module: `drive_host_regs`

## Requirements
- R1: A read of offset 0 returns the status byte without side effects. Bits 1:0 hold the bank index. Bit 2 is always 0. Bit 3 is 1 when the parameter queue is empty. Bit 4 is 1 when the parameter queue is not full. Bit 5 is 1 when the response queue holds data. Bit 6 is 1 when the data queue holds data. Bit 7 equals `seq_busy_i`.
- R2: A write to offset 0 changes only the bank index, which takes bits 1:0 of the written byte.
- R3: A read of offset 1 returns the oldest response byte and removes it. A read of offset 2 returns the oldest data byte and removes it, whatever the bank index.
- R4: A read of an empty response queue or an empty data queue returns 0x00 and leaves that queue empty.
- R5: A read of offset 3 with bank index 0 or 2 returns the enable register in bits 4:0 with bits 7:5 set to 1. With bank index 1 or 3 it returns the flag register in bits 4:0 with bits 7:5 set to 0.
- R6: A write to offset 1 with bank index 0 while `seq_busy_i` is low raises `cmd_valid_o` in that same cycle, with `cmd_op_o` equal to the written byte. While `seq_busy_i` is high the write is dropped and `cmd_valid_o` stays low.
- R7: A write to offset 3 with bank index 1 clears every flag bit whose position in bits 4:0 of the written byte is 1. Bits 7:5 of the written byte have no effect.
- R8: A write to offset 2 with bank index 1 loads the enable register from bits 4:0 of the written byte.
- R9: A write to offset 2 with bank index 0 appends the byte to the parameter queue, which is 16 deep. A write to a full queue is dropped. `prm_data_o` presents the oldest entry, and `prm_pop_i` removes it.
- R10: After reset the enable register is 0x1F, the flag register is 0, the bank index is 0 and all three queues are empty.
- R11: `irq_set_i` replaces the whole flag register with `irq_code_i` at the next edge; the code is not merged with older flags. If a clearing write falls in the same cycle, the new code wins.
- R12: `irq_o` is high exactly when some bit is set in both the flag and the enable registers.
- R13: If a push and a pop reach the same non-empty queue in one cycle, both take effect: the oldest byte leaves and the new byte is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Host register offset |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe (pops take effect at the clock edge) |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data (combinational) |
| seq_busy_i | input | 1 | Command sequencer is not idle |
| cmd_valid_o | output | 1 | Command start strobe |
| cmd_op_o | output | 8 | Command opcode |
| prm_pop_i | input | 1 | Sequencer pops the parameter queue |
| prm_data_o | output | 8 | Oldest parameter byte (0 when the queue is empty) |
| rsp_push_i | input | 1 | Sequencer pushes a response byte |
| rsp_data_i | input | 8 | Response byte |
| dat_push_i | input | 1 | Sequencer pushes a data byte |
| dat_data_i | input | 8 | Data byte |
| irq_set_i | input | 1 | Raise interrupt with a code |
| irq_code_i | input | 5 | Interrupt code |
| prm_push_o | output | 1 | Host parameter write strobe |
| rsp_pop_o | output | 1 | Host response read strobe |
| dat_pop_o | output | 1 | Host data read strobe |
| irq_o | output | 1 | Interrupt request level |

## Verification
Two kinds of event can fall in the same cycle. The first is the sequencer raising an interrupt while the host writes ones to clear flags. The second is the sequencer pushing a response byte while the host pops the same queue. The bench provokes both by driving the two inputs in one cycle. For the interrupt case, it then reads the flag register and expects the new code alone. For the queue case, it expects the old head byte on the popping read and the pushed byte on the read that follows.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int IRQ_W = 5;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {
    OFS_STAT = 2'd0,
    OFS_CMD  = 2'd1,
    OFS_DAT  = 2'd2,
    OFS_IRQ  = 2'd3
  } ofs_e;
endpackage

// File: rtl/hreg_fifo.sv
module hreg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0]   cnt;
  logic          pop_ok, push_ok;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == FULL_CNT);
  assign pop_ok  = pop_i && !empty_o;
  // a full queue still accepts a push when a pop frees a slot in the same cycle
  assign push_ok = push_i && (!full_o || pop_ok);
  assign data_o  = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/hreg_irq.sv
module hreg_irq
  import hreg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] wdata_i,
  input  logic             set_i,
  input  logic [IRQ_W-1:0] code_i,
  output logic [IRQ_W-1:0] en_o,
  output logic [IRQ_W-1:0] flag_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '1;
      flag_o <= '0;
    end else begin
      if (en_we_i) en_o <= wdata_i;
      if (set_i)         flag_o <= code_i;     // raise overwrites, wins over clear
      else if (clr_we_i) flag_o <= flag_o & ~wdata_i;
    end
  end

  assign irq_o = |(flag_o & en_o);
endmodule

// File: rtl/drive_host_regs.sv
module drive_host_regs
  import hreg_pkg::*;
#(
  parameter int PRM_DEPTH = 16,
  parameter int RSP_DEPTH = 16,
  parameter int DAT_DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              seq_busy_i,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_op_o,
  input  logic              prm_pop_i,
  output logic [BYTE_W-1:0] prm_data_o,
  input  logic              rsp_push_i,
  input  logic [BYTE_W-1:0] rsp_data_i,
  input  logic              dat_push_i,
  input  logic [BYTE_W-1:0] dat_data_i,
  input  logic              irq_set_i,
  input  logic [IRQ_W-1:0]  irq_code_i,
  output logic              prm_push_o,
  output logic              rsp_pop_o,
  output logic              dat_pop_o,
  output logic              irq_o
);
  localparam int PAD_W = BYTE_W - IRQ_W;

  logic [1:0]        idx_q;
  logic              prm_empty, prm_full, rsp_empty, rsp_full, dat_empty, dat_full;
  logic [BYTE_W-1:0] rsp_head, dat_head;
  logic [IRQ_W-1:0]  irq_en, irq_flag;
  logic              en_we, clr_we;
  logic [BYTE_W-1:0] stat_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              idx_q <= '0;
    else if (wr_i && addr_i == OFS_STAT)      idx_q <= wdata_i[1:0];
  end

  assign cmd_valid_o = wr_i && addr_i == OFS_CMD && idx_q == 2'd0 && !seq_busy_i;
  assign cmd_op_o    = wdata_i;
  assign prm_push_o  = wr_i && addr_i == OFS_DAT && idx_q == 2'd0;
  assign en_we       = wr_i && addr_i == OFS_DAT && idx_q == 2'd1;
  assign clr_we      = wr_i && addr_i == OFS_IRQ && idx_q == 2'd1;
  assign rsp_pop_o   = rd_i && addr_i == OFS_CMD;
  assign dat_pop_o   = rd_i && addr_i == OFS_DAT;

  hreg_fifo #(.W(BYTE_W), .DEPTH(PRM_DEPTH)) u_prm_fifo (
    .clk_i, .rst_ni,
    .push_i(prm_push_o), .data_i(wdata_i),
    .pop_i(prm_pop_i),   .data_o(prm_data_o),
    .empty_o(prm_empty), .full_o(prm_full)
  );

  hreg_fifo #(.W(BYTE_W), .DEPTH(RSP_DEPTH)) u_rsp_fifo (
    .clk_i, .rst_ni,
    .push_i(rsp_push_i), .data_i(rsp_data_i),
    .pop_i(rsp_pop_o),   .data_o(rsp_head),
    .empty_o(rsp_empty), .full_o(rsp_full)
  );

  hreg_fifo #(.W(BYTE_W), .DEPTH(DAT_DEPTH)) u_dat_fifo (
    .clk_i, .rst_ni,
    .push_i(dat_push_i), .data_i(dat_data_i),
    .pop_i(dat_pop_o),   .data_o(dat_head),
    .empty_o(dat_empty), .full_o(dat_full)
  );

  hreg_irq u_irq (
    .clk_i, .rst_ni,
    .en_we_i(en_we), .clr_we_i(clr_we),
    .wdata_i(wdata_i[IRQ_W-1:0]),
    .set_i(irq_set_i), .code_i(irq_code_i),
    .en_o(irq_en), .flag_o(irq_flag), .irq_o(irq_o)
  );

  assign stat_byte = {seq_busy_i, !dat_empty, !rsp_empty, !prm_full, prm_empty, 1'b0, idx_q};

  always_comb begin
    unique case (addr_i)
      OFS_STAT: rdata_o = stat_byte;
      OFS_CMD:  rdata_o = rsp_head;
      OFS_DAT:  rdata_o = dat_head;
      default:  rdata_o = idx_q[0] ? {{PAD_W{1'b0}}, irq_flag} : {{PAD_W{1'b1}}, irq_en};
    endcase
  end

  // full flags of the host-drained queues are not exposed
  logic unused_full;
  assign unused_full = rsp_full ^ dat_full;
endmodule

module drive_host_regs_chk
  import hreg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              seq_busy_i,
  input logic              cmd_valid_o,
  input logic              irq_set_i,
  input logic [IRQ_W-1:0]  irq_code_i,
  input logic [IRQ_W-1:0]  irq_flag,
  input logic              irq_o,
  input logic [1:0]        idx_q,
  input logic              rsp_empty
);
  AST_BUSY_DROPS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy_i |-> !cmd_valid_o); // R6

  AST_STAT_BIT2_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd0) |-> !rdata_o[2]); // R1

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd1 && rsp_empty) |-> rdata_o == 8'h00); // R4

  AST_RAISE_OVERWRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_flag == $past(irq_code_i)); // R11

  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3 && idx_q == 2'd1 && !irq_set_i)
      |=> irq_flag == ($past(irq_flag) & ~$past(wdata_i[IRQ_W-1:0]))); // R7

  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag == '0) |-> !irq_o); // R12
endmodule

bind drive_host_regs drive_host_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .seq_busy_i(seq_busy_i),
  .cmd_valid_o(cmd_valid_o), .irq_set_i(irq_set_i), .irq_code_i(irq_code_i),
  .irq_flag(irq_flag), .irq_o(irq_o), .idx_q(idx_q), .rsp_empty(rsp_empty)
);

// File: tb/drive_host_regs_bench.sv
module drive_host_regs_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       seq_busy_i = 1'b0;
  logic       cmd_valid_o;
  logic [7:0] cmd_op_o;
  logic       prm_pop_i = 1'b0;
  logic [7:0] prm_data_o;
  logic       rsp_push_i = 1'b0;
  logic [7:0] rsp_data_i = '0;
  logic       dat_push_i = 1'b0;
  logic [7:0] dat_data_i = '0;
  logic       irq_set_i = 1'b0;
  logic [4:0] irq_code_i = '0;
  logic       prm_push_o, rsp_pop_o, dat_pop_o, irq_o;

  always #5 clk_i = ~clk_i;

  drive_host_regs u_drive_host_regs (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  task automatic expect_byte(input logic [7:0] act, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    act_q.push_back(act);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", t, a, e);
      end
    end
  endtask

  // monitor: compares queued results as they are produced
  initial forever begin
    @(posedge clk_i);
    drain();
  end

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #2 d = rdata_o;
    @(posedge clk_i); #1 rd_i = 1'b0;
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b1; wdata_i = v;
    @(posedge clk_i); #1 wr_i = 1'b0;
  endtask

  task automatic raise(input logic [4:0] c);
    @(negedge clk_i);
    irq_set_i = 1'b1; irq_code_i = c;
    @(posedge clk_i); #1 irq_set_i = 1'b0;
  endtask

  task automatic rsp_push(input logic [7:0] v);
    @(negedge clk_i);
    rsp_push_i = 1'b1; rsp_data_i = v;
    @(posedge clk_i); #1 rsp_push_i = 1'b0;
  endtask

  task automatic dat_push(input logic [7:0] v);
    @(negedge clk_i);
    dat_push_i = 1'b1; dat_data_i = v;
    @(posedge clk_i); #1 dat_push_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R10 / R1: reset state
    host_rd(2'd0, d); expect_byte(d, 8'h18, "R10 status after reset");
    host_rd(2'd3, d); expect_byte(d, 8'hFF, "R10 R5 enable after reset");
    host_wr(2'd0, 8'h01);
    host_rd(2'd3, d); expect_byte(d, 8'h00, "R10 R5 flag after reset");

    // R2: only index bits are taken
    host_wr(2'd0, 8'hFE);
    host_rd(2'd0, d); expect_byte(d, 8'h1A, "R2 index from write");
    host_wr(2'd0, 8'h00);

    // R9: parameter queue fill, overflow drop, ordered drain
    for (int i = 0; i < 17; i++) begin
      @(negedge clk_i);
      addr_i = 2'd2; wr_i = 1'b1; wdata_i = 8'h40 + 8'(i);
      #2 if (i == 0) expect_byte({7'b0, prm_push_o}, 8'h01, "R9 push strobe");
      @(posedge clk_i); #1 wr_i = 1'b0;
    end
    host_rd(2'd0, d); expect_byte(d, 8'h00, "R9 R1 param full status");
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      prm_pop_i = 1'b1;
      #2 expect_byte(prm_data_o, 8'h40 + 8'(i), "R9 param order");
      @(posedge clk_i); #1 prm_pop_i = 1'b0;
    end
    host_rd(2'd0, d); expect_byte(d, 8'h18, "R9 overflow byte dropped");
    #2 expect_byte(prm_data_o, 8'h00, "R9 empty param head");

    // R3 / R4 / R13: response queue
    rsp_push(8'hA1);
    host_rd(2'd0, d); expect_byte(d, 8'h38, "R1 response pending bit");
    @(negedge clk_i);
    addr_i = 2'd1; rd_i = 1'b1; rsp_push_i = 1'b1; rsp_data_i = 8'hB2;
    #2 expect_byte(rdata_o, 8'hA1, "R13 pop side of push+pop");
    expect_byte({7'b0, rsp_pop_o}, 8'h01, "R3 response pop strobe");
    @(posedge clk_i); #1 rd_i = 1'b0; rsp_push_i = 1'b0;
    host_rd(2'd1, d); expect_byte(d, 8'hB2, "R13 push side of push+pop");
    host_rd(2'd1, d); expect_byte(d, 8'h00, "R4 empty response pop");
    host_rd(2'd0, d); expect_byte(d, 8'h18, "R4 response stays empty");

    // R3 / R4: data queue under bank index 1
    dat_push(8'hC3); dat_push(8'hD4);
    host_wr(2'd0, 8'h01);
    host_rd(2'd0, d); expect_byte(d, 8'h59, "R1 data pending bit");
    host_rd(2'd2, d); expect_byte(d, 8'hC3, "R3 data pop idx1");
    host_rd(2'd2, d); expect_byte(d, 8'hD4, "R3 data pop second");
    host_rd(2'd2, d); expect_byte(d, 8'h00, "R4 empty data pop");
    host_rd(2'd0, d); expect_byte(d, 8'h19, "R4 data stays empty");

    // R11 / R12 / R7 / R5: interrupts (index is 1)
    raise(5'd3);
    #1 expect_byte({7'b0, irq_o}, 8'h01, "R12 irq high");
    host_rd(2'd3, d); expect_byte(d, 8'h03, "R11 flag code");
    raise(5'd1);
    host_rd(2'd3, d); expect_byte(d, 8'h01, "R11 overwrite not merge");
    raise(5'd7);
    host_wr(2'd3, 8'hE2);
    host_rd(2'd3, d); expect_byte(d, 8'h05, "R7 partial clear");
    host_wr(2'd3, 8'hFF);
    host_rd(2'd3, d); expect_byte(d, 8'h00, "R7 full clear");
    #1 expect_byte({7'b0, irq_o}, 8'h00, "R12 irq low");
    raise(5'd1);
    @(negedge clk_i);
    addr_i = 2'd3; wr_i = 1'b1; wdata_i = 8'h1F; irq_set_i = 1'b1; irq_code_i = 5'd4;
    @(posedge clk_i); #1 wr_i = 1'b0; irq_set_i = 1'b0;
    host_rd(2'd3, d); expect_byte(d, 8'h04, "R11 raise beats clear");

    // R8 / R12 / R5
    host_wr(2'd2, 8'hE0);
    #1 expect_byte({7'b0, irq_o}, 8'h00, "R12 masked");
    host_wr(2'd0, 8'h02);
    host_rd(2'd3, d); expect_byte(d, 8'hE0, "R8 R5 enable idx2");
    host_wr(2'd0, 8'h01);
    host_wr(2'd2, 8'h04);
    #1 expect_byte({7'b0, irq_o}, 8'h01, "R12 unmasked");
    host_wr(2'd0, 8'h00);
    host_rd(2'd3, d); expect_byte(d, 8'hE4, "R8 R5 enable idx0");

    // R6: command issue and busy drop
    @(negedge clk_i);
    addr_i = 2'd1; wr_i = 1'b1; wdata_i = 8'h19; seq_busy_i = 1'b0;
    #2 expect_byte({7'b0, cmd_valid_o}, 8'h01, "R6 cmd strobe idle");
    expect_byte(cmd_op_o, 8'h19, "R6 cmd opcode");
    @(posedge clk_i); #1 wr_i = 1'b0;
    @(negedge clk_i);
    seq_busy_i = 1'b1; addr_i = 2'd1; wr_i = 1'b1; wdata_i = 8'h1A;
    #2 expect_byte({7'b0, cmd_valid_o}, 8'h00, "R6 cmd dropped busy");
    @(posedge clk_i); #1 wr_i = 1'b0;
    host_rd(2'd0, d); expect_byte(d, 8'h98, "R1 busy bit");
    seq_busy_i = 1'b0;

    @(posedge clk_i); #1;
    drain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule